// File: doc/BRIEF.md
# Real-Time Clock Counting Front End

This block is the counting path of a real-time clock. Four oscillator sources arrive as single-cycle tick pulses, all sampled in one system clock. A two-bit source code picks one of them. A run bit gates the chosen tick. Two prescalers then follow in a fixed order: a first stage dividing by `PRE_A` (512 by default) and a second stage dividing by `PRE_B` (32 by default). Each stage can be bypassed on its own. The tick that leaves the chain advances a free-running counter of `CNT_W` bits, 32 by default. That tick is also available on an output.

Software sets up the path through a one-cycle configuration write that carries every field at once. While the low-power flag is high, configuration writes are dropped, but the counter keeps counting. The reset input has a qualifier. A plain reset returns the counter, the configuration and the prescalers to their reset state. When the reset is flagged as coming from the software watchdog, nothing is disturbed.

Top module: `rtc_tick_front`

## Requirements
- R1: Source code 2'b00 selects the slow internal RC tick, taken through a fixed divide-by-4. Code 2'b01 selects the slow crystal tick, 2'b10 the fast internal RC tick and 2'b11 the fast crystal tick. Ticks on sources that are not selected never reach the counter.
- R2: While the run bit is 0, no tick passes, the counter holds its value and both prescaler counts are held at zero. Once run is set again, a full prescaler period is needed before the next count.
- R3: With the first prescaler enabled, it passes one tick for every `PRE_A` ticks it receives. With it disabled, ticks pass through undivided.
- R4: The second prescaler takes the output of the first. With it enabled, it passes one tick for every `PRE_B` ticks it receives. With it disabled, ticks pass through undivided.
- R5: For every combination of the two prescaler enables, the number of source ticks per count equals the product of the active division factors, including the divide-by-4 when source 2'b00 is selected.
- R6: After a reset, the counter is 0, the source code is 2'b00, run is 0, both prescalers are bypassed and `rollover` is low.
- R7: A reset with `rst_swdog` low clears the counter, the configuration and all prescaler counts. A reset with `rst_swdog` high leaves the counter, the configuration and the prescaler counts unchanged.
- R8: While `low_power` is 1, configuration writes have no effect, and counting continues with the configuration already in place.
- R9: The counter wraps from its all-ones value to 0. The cycle in which it shows 0 after the wrap, `rollover` is high for exactly one cycle.
- R10: A configuration write that changes the source code or either prescaler enable clears all prescaler counts, so the next count needs a full period.
- R11: `sel_tick` is high in the same cycle as the source tick that completes a period. The counter shows the increment from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset request |
| rst_swdog | input | 1 | Marks the reset request as a software watchdog reset (no effect) |
| low_power | input | 1 | Low-power flag; blocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Source code to write |
| cfg_run | input | 1 | Run bit to write |
| cfg_pre_a_on | input | 1 | First prescaler enable to write |
| cfg_pre_b_on | input | 1 | Second prescaler enable to write |
| tick_slow_rc | input | 1 | Slow internal RC tick (code 00) |
| tick_slow_xtal | input | 1 | Slow crystal tick (code 01) |
| tick_fast_rc | input | 1 | Fast internal RC tick (code 10) |
| tick_fast_xtal | input | 1 | Fast crystal tick (code 11) |
| count | output | CNT_W (32) | Counter value |
| rollover | output | 1 | One-cycle pulse after the counter wraps to 0 |
| sel_tick | output | 1 | Tick leaving the prescaler chain |

## Verification
The assertions assume that no configuration write is presented while a watchdog-flagged reset is active. They also assume that the reset qualifier settles before the clock edge, so that a destructive reset is seen as a whole cycle. The stimulus meets both conditions. It drives ticks, writes and resets only at the falling edge. It never overlaps a write with a reset, and it keeps all ticks low while a configuration write is in flight, so every counted period starts from a known prescaler state. Every division ratio is exercised on the fast internal RC source and on the divided slow RC source. The bench uses a small parameter set so that wrap and ratio sweeps finish quickly.

// File: rtl/rtc_front_pkg.sv
package rtc_front_pkg;

    typedef enum logic [1:0] {
        SRC_SLOW_RC   = 2'b00,
        SRC_SLOW_XTAL = 2'b01,
        SRC_FAST_RC   = 2'b10,
        SRC_FAST_XTAL = 2'b11
    } src_sel_e;

    localparam int NUM_SRC      = 4;
    localparam int SLOW_RC_DIV  = 4;

    typedef struct packed {
        src_sel_e sel;
        logic     run;
        logic     pre_a_on;
        logic     pre_b_on;
    } rtc_cfg_t;

    localparam rtc_cfg_t CFG_RESET = '{
        sel:      SRC_SLOW_RC,
        run:      1'b0,
        pre_a_on: 1'b0,
        pre_b_on: 1'b0
    };

    // True when a new setting alters the division path and prescaler
    // history must be discarded.
    function automatic logic timebase_changed(input rtc_cfg_t old_c,
                                              input rtc_cfg_t new_c);
        return (old_c.sel != new_c.sel) ||
               (old_c.pre_a_on != new_c.pre_a_on) ||
               (old_c.pre_b_on != new_c.pre_b_on);
    endfunction

endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale #(
    parameter int N = 512
) (
    input  logic clk,
    input  logic rst_d,
    input  logic clr,
    input  logic en,
    input  logic tick_in,
    output logic tick_out
);
    localparam int W = (N > 1) ? $clog2(N) : 1;

    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end   = (cnt_q == W'(N - 1));
    assign tick_out = en ? (tick_in && at_end) : tick_in;

    always_ff @(posedge clk) begin
        if (rst_d || clr || !en) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_src_mux.sv
module rtc_src_mux
    import rtc_front_pkg::*;
(
    input  src_sel_e           sel,
    input  logic               run,
    input  logic [NUM_SRC-1:0] src_ticks,
    input  logic               slow_div_tick,
    output logic               slow_gated,
    output logic               mux_tick
);
    logic [NUM_SRC-1:0] gated;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
        assign gated[i] = run && (sel == src_sel_e'(i)) && src_ticks[i];
    end

    assign slow_gated = gated[SRC_SLOW_RC];

    always_comb begin
        if (sel == SRC_SLOW_RC) begin
            mux_tick = slow_div_tick;
        end else begin
            mux_tick = |gated[NUM_SRC-1:1];
        end
    end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_d,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             rollover
);
    logic [CNT_W-1:0] cnt_q;
    logic             roll_q;

    always_ff @(posedge clk) begin
        if (rst_d) begin
            cnt_q  <= '0;
            roll_q <= 1'b0;
        end else begin
            roll_q <= inc && (cnt_q == '1);
            if (inc) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign count    = cnt_q;
    assign rollover = roll_q;
endmodule

// File: rtl/rtc_tick_front.sv
module rtc_tick_front
    import rtc_front_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_A = 512,
    parameter int PRE_B = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_swdog,
    input  logic             low_power,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic             cfg_run,
    input  logic             cfg_pre_a_on,
    input  logic             cfg_pre_b_on,
    input  logic             tick_slow_rc,
    input  logic             tick_slow_xtal,
    input  logic             tick_fast_rc,
    input  logic             tick_fast_xtal,
    output logic [CNT_W-1:0] count,
    output logic             rollover,
    output logic             sel_tick
);
    logic               rst_d;
    logic               cfg_fire;
    logic               pre_clr;
    rtc_cfg_t           cfg_q;
    rtc_cfg_t           cfg_new;
    logic [NUM_SRC-1:0] src_ticks;
    logic               slow_gated;
    logic               slow_div_tick;
    logic               mux_tick;
    logic               stage_a_tick;
    logic               stage_b_tick;

    // Watchdog-flagged resets leave the block untouched.
    assign rst_d    = rst && !rst_swdog;
    assign cfg_fire = cfg_we && !low_power;

    assign cfg_new = '{
        sel:      src_sel_e'(cfg_sel),
        run:      cfg_run,
        pre_a_on: cfg_pre_a_on,
        pre_b_on: cfg_pre_b_on
    };

    always_ff @(posedge clk) begin
        if (rst_d) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_fire) begin
            cfg_q <= cfg_new;
        end
    end

    assign pre_clr = (cfg_fire && timebase_changed(cfg_q, cfg_new)) || !cfg_q.run;

    assign src_ticks = {tick_fast_xtal, tick_fast_rc, tick_slow_xtal, tick_slow_rc};

    rtc_src_mux u_mux (
        .sel           (cfg_q.sel),
        .run           (cfg_q.run),
        .src_ticks     (src_ticks),
        .slow_div_tick (slow_div_tick),
        .slow_gated    (slow_gated),
        .mux_tick      (mux_tick)
    );

    rtc_prescale #(.N(SLOW_RC_DIV)) u_slow_div (
        .clk      (clk),
        .rst_d    (rst_d),
        .clr      (pre_clr),
        .en       (1'b1),
        .tick_in  (slow_gated),
        .tick_out (slow_div_tick)
    );

    rtc_prescale #(.N(PRE_A)) u_pre_a (
        .clk      (clk),
        .rst_d    (rst_d),
        .clr      (pre_clr),
        .en       (cfg_q.pre_a_on),
        .tick_in  (mux_tick),
        .tick_out (stage_a_tick)
    );

    rtc_prescale #(.N(PRE_B)) u_pre_b (
        .clk      (clk),
        .rst_d    (rst_d),
        .clr      (pre_clr),
        .en       (cfg_q.pre_b_on),
        .tick_in  (stage_a_tick),
        .tick_out (stage_b_tick)
    );

    assign sel_tick = stage_b_tick;

    rtc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_d    (rst_d),
        .inc      (stage_b_tick),
        .count    (count),
        .rollover (rollover)
    );
endmodule

// File: rtl/rtc_tick_front_chk.sv
module rtc_tick_front_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             rst_swdog,
    input logic             low_power,
    input logic             cfg_we,
    input logic [3:0]       src_ticks,
    input logic [1:0]       sel_q,
    input logic             run_q,
    input logic             pre_a_q,
    input logic             pre_b_q,
    input logic [CNT_W-1:0] count,
    input logic             rollover,
    input logic             sel_tick
);
    logic       destr;
    logic [4:0] cfg_bits;

    assign destr    = rst && !rst_swdog;
    assign cfg_bits = {sel_q, run_q, pre_a_q, pre_b_q};

    assert_select_R1: assert property (@(posedge clk) disable iff (destr)
        sel_tick |-> (run_q && src_ticks[sel_q]));

    assert_idle_R2: assert property (@(posedge clk) disable iff (destr)
        !run_q |-> !sel_tick);

    assert_reset_R6: assert property (@(posedge clk)
        destr |=> (count == '0 && !run_q && sel_q == 2'b00 && !pre_a_q && !pre_b_q && !rollover));

    assert_swdog_R7: assert property (@(posedge clk) disable iff (destr)
        (rst && rst_swdog && !cfg_we) |=> $stable(cfg_bits));

    assert_lowpower_R8: assert property (@(posedge clk) disable iff (destr)
        low_power |=> $stable(cfg_bits));

    assert_wrap_R9: assert property (@(posedge clk) disable iff (destr)
        rollover |-> (count == '0));

    assert_inc_R11: assert property (@(posedge clk) disable iff (destr)
        1'b1 |=> (count == $past(count) + CNT_W'($past(sel_tick))));
endmodule

bind rtc_tick_front rtc_tick_front_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rst_swdog (rst_swdog),
    .low_power (low_power),
    .cfg_we    (cfg_we),
    .src_ticks (src_ticks),
    .sel_q     (cfg_q.sel),
    .run_q     (cfg_q.run),
    .pre_a_q   (cfg_q.pre_a_on),
    .pre_b_q   (cfg_q.pre_b_on),
    .count     (count),
    .rollover  (rollover),
    .sel_tick  (sel_tick)
);

// File: tb/rtc_tick_front_bench.sv
module rtc_tick_front_bench;
    localparam int CW   = 10;
    localparam int PA   = 8;
    localparam int PB   = 4;
    localparam int MODV = 1 << CW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rst_swdog = 1'b0;
    logic          low_power = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'b00;
    logic          cfg_run = 1'b0;
    logic          cfg_pre_a_on = 1'b0;
    logic          cfg_pre_b_on = 1'b0;
    logic [3:0]    ticks = 4'b0;
    logic [CW-1:0] count;
    logic          rollover;
    logic          sel_tick;

    int checks = 0;
    int errors = 0;
    int base;

    always #4 clk = ~clk;

    rtc_tick_front #(.CNT_W(CW), .PRE_A(PA), .PRE_B(PB)) u_rtc_tick_front (
        .clk            (clk),
        .rst            (rst),
        .rst_swdog      (rst_swdog),
        .low_power      (low_power),
        .cfg_we         (cfg_we),
        .cfg_sel        (cfg_sel),
        .cfg_run        (cfg_run),
        .cfg_pre_a_on   (cfg_pre_a_on),
        .cfg_pre_b_on   (cfg_pre_b_on),
        .tick_slow_rc   (ticks[0]),
        .tick_slow_xtal (ticks[1]),
        .tick_fast_rc   (ticks[2]),
        .tick_fast_xtal (ticks[3]),
        .count          (count),
        .rollover       (rollover),
        .sel_tick       (sel_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int sel, input bit run, input bit a, input bit b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_run = run;
        cfg_pre_a_on = a; cfg_pre_b_on = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic feed(input int src, input int n);
        if (n > 0) begin
            @(negedge clk);
            ticks[src] = 1'b1;
            repeat (n) @(negedge clk);
            ticks[src] = 1'b0;
        end
    endtask

    function automatic int plus(input int b, input int k);
        return (b + k) % MODV;
    endfunction

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R6: reset state, nothing counts while run is 0
        chk("R6 count", int'(count), 0);
        chk("R6 rollover", int'(rollover), 0);
        for (int s = 0; s < 4; s++) feed(s, 4);
        chk("R6 idle after reset", int'(count), 0);

        // R1: each code against each source
        for (int s = 0; s < 4; s++) begin
            write_cfg(s, 1'b1, 1'b0, 1'b0);
            for (int src = 0; src < 4; src++) begin
                base = int'(count);
                feed(src, 8);
                chk($sformatf("R1 sel=%0d src=%0d", s, src), int'(count),
                    plus(base, (src == s) ? ((s == 0) ? 2 : 8) : 0));
            end
        end

        // R3 R4 R5: every prescaler combination on two sources
        for (int pass = 0; pass < 2; pass++) begin
            for (int ab = 0; ab < 4; ab++) begin
                automatic int s = (pass == 0) ? 2 : 0;
                automatic bit a = ab[0];
                automatic bit b = ab[1];
                automatic int r = (a ? PA : 1) * (b ? PB : 1) * ((s == 0) ? 4 : 1);
                write_cfg(s, 1'b1, a, b);
                base = int'(count);
                feed(s, 3 * r - 1);
                chk($sformatf("R5 R3 R4 short sel=%0d a=%0d b=%0d", s, a, b), int'(count), plus(base, 2));
                feed(s, 1);
                chk($sformatf("R5 R3 R4 full sel=%0d a=%0d b=%0d", s, a, b), int'(count), plus(base, 3));
            end
        end

        // R10: a timebase change discards partial prescaler counts
        write_cfg(2, 1'b1, 1'b1, 1'b0);
        base = int'(count);
        feed(2, 5);
        write_cfg(2, 1'b1, 1'b1, 1'b1);
        write_cfg(2, 1'b1, 1'b1, 1'b0);
        feed(2, 7);
        chk("R10 no count after clear", int'(count), base);
        feed(2, 1);
        chk("R10 count after full period", int'(count), plus(base, 1));

        // R2: run cleared holds count and zeroes prescalers
        base = int'(count);
        feed(2, 5);
        write_cfg(2, 1'b0, 1'b1, 1'b0);
        feed(2, 20);
        chk("R2 hold while stopped", int'(count), base);
        write_cfg(2, 1'b1, 1'b1, 1'b0);
        feed(2, 7);
        chk("R2 prescaler restarted", int'(count), base);
        feed(2, 1);
        chk("R2 full period after restart", int'(count), plus(base, 1));

        // R11: sel_tick timing relative to count
        write_cfg(3, 1'b1, 1'b0, 1'b0);
        base = int'(count);
        @(negedge clk);
        ticks[3] = 1'b1;
        #1;
        chk("R11 sel_tick same cycle", int'(sel_tick), 1);
        chk("R11 count not yet", int'(count), base);
        @(negedge clk);
        ticks[3] = 1'b0;
        #1;
        chk("R11 count next cycle", int'(count), plus(base, 1));
        chk("R11 sel_tick low", int'(sel_tick), 0);

        // R8: writes ignored in low power, counting continues
        write_cfg(2, 1'b1, 1'b0, 1'b0);
        low_power = 1'b1;
        write_cfg(1, 1'b0, 1'b1, 1'b1);
        base = int'(count);
        feed(2, 5);
        chk("R8 counting in low power", int'(count), plus(base, 5));
        low_power = 1'b0;

        // R7: watchdog reset preserves state including prescaler progress
        write_cfg(2, 1'b1, 1'b1, 1'b0);
        base = int'(count);
        feed(2, 3);
        @(negedge clk);
        rst = 1'b1; rst_swdog = 1'b1;
        @(negedge clk);
        rst = 1'b0; rst_swdog = 1'b0;
        chk("R7 watchdog keeps count", int'(count), base);
        feed(2, 5);
        chk("R7 watchdog keeps prescaler", int'(count), plus(base, 1));
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R7 destructive clears count", int'(count), 0);
        feed(2, 10);
        chk("R7 destructive clears run", int'(count), 0);

        // R9: wrap and rollover pulse
        write_cfg(2, 1'b1, 1'b0, 1'b0);
        feed(2, MODV - 1);
        chk("R9 at max", int'(count), MODV - 1);
        chk("R9 no early rollover", int'(rollover), 0);
        feed(2, 1);
        chk("R9 wrapped", int'(count), 0);
        chk("R9 rollover high", int'(rollover), 1);
        @(negedge clk);
        chk("R9 rollover one cycle", int'(rollover), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule